// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Unit

This block routes a set of external interrupt lines (24 by default) to one CPU-side message port. Each line has its own 64-bit redirection entry. The entry selects the interrupt vector, the delivery mode, how the destination is read (physical or logical), the destination itself, the active polarity, edge or level triggering, and a mask. When an unmasked line becomes active, the unit raises a message on a valid/ready port. If several lines are waiting, the lowest-numbered line goes first.

Software never addresses the table directly. A 32-bit register port exposes two locations: a select register and a data window. Software writes a register index into the select register, then reads or writes the window. Index 0x00 holds the unit identifier. Entry n sits at index 0x10+2n (low half) and 0x11+2n (high half).

A level-triggered line is locked after one accepted message. It stays locked until an end-of-interrupt input carries the vector of that entry.

Top module: `intredir_top`

## Requirements
- R1: The select register is at byte offset 0x00, and reading offset 0x00 returns the stored 8-bit index in bits 7:0. Offset 0x10 is the data window, which reads and writes the register named by the select index. Other offsets read zero.
- R2: Index 0x00 is the identifier register. Bits 31:24 are writable and read back. Its other bits read zero. It resets to zero.
- R3: The low half of entry n is at index 0x10+2n and the high half at 0x11+2n. The high half keeps the destination in bits 31:24; its other bits read zero. Any index outside 0x00 and 0x10..0x10+2N-1 reads zero and ignores writes.
- R4: The low-half layout is:
  - vector in bits 7:0
  - delivery mode in 10:8 (fixed 0, lowest priority 1, SMI 2, NMI 4, INIT 5, external 7)
  - destination mode in bit 11 (0 physical, 1 logical)
  - delivery status in bit 12
  - polarity in bit 13 (0 active high, 1 active low)
  - remote-busy in bit 14
  - trigger in bit 15 (0 edge, 1 level)
  - mask in bit 16 (1 masked)
  
  Bits 12 and 14 are read-only and ignore writes.
- R5: After reset every entry reads 0x00010000 in its low half: masked, edge, active high, vector 0. Every high half reads 0, and msg_valid is 0.
- R6: A masked line never produces a message. An active transition seen while masked is not remembered after the entry is unmasked.
- R7: On an edge-triggered entry, an inactive-to-active transition sets pending, which reads as delivery status 1. msg_valid rises at the second rising clock edge after the line changes. Each transition yields exactly one message.
- R8: With polarity 1, the line is active when low, so a high-to-low transition triggers.
- R9: The message carries the entry's vector, delivery mode, destination mode and destination. All of these fields stay stable while msg_valid is 1 and msg_ready is 0.
- R10: When several lines are requesting, the lowest-numbered one is sent first. On the handshake, msg_valid drops for one cycle. The pending flag clears, so delivery status reads 0.
- R11: A level-triggered entry sets remote-busy when its message is accepted. While remote-busy is set, the entry sends nothing more. An eoi_valid pulse whose eoi_vector equals the entry's vector clears remote-busy, and a still-active line then requests again. An end-of-interrupt carrying another vector has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset: 0x00 select, 0x10 window |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_in | input | 24 | External interrupt lines |
| msg_valid | output | 1 | Interrupt message offered |
| msg_ready | input | 1 | CPU accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest_logical | output | 1 | Destination mode (1 logical) |
| msg_dest | output | 8 | Destination |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being ended |

## Verification
- **Line change to message:** a line change is registered at the first rising edge, which sets pending. The message register loads at the second edge. The bench therefore drives inputs on falling edges and checks msg_valid two falling edges later, after first confirming it is still low one falling edge after the change.
- **Handshake:** a handshake clears msg_valid at the accepting edge, and the next winner loads one edge later. The bench checks for the drop and then for the next vector at consecutive falling edges.
- **End of interrupt:** an end-of-interrupt clears remote-busy at its edge, so a still-active level line is offered again two falling edges after the pulse is driven.
- **Register reads:** reads are combinational from the stored select and state, so they are sampled 1 ns after the address settles.

// File: rtl/intredir_pkg.sv
package intredir_pkg;

    localparam int DATA_W  = 32;
    localparam int VEC_W   = 8;
    localparam int MODE_W  = 3;
    localparam int DEST_W  = 8;
    localparam int SEL_W   = 8;
    localparam int ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] SEL_OFS = 5'h00;
    localparam logic [ADDR_W-1:0] WIN_OFS = 5'h10;

    localparam logic [SEL_W-1:0] ID_IDX   = 8'h00;
    localparam logic [SEL_W-1:0] TBL_BASE = 8'h10;

    // low-half bit positions
    localparam int B_DLOG   = 11;
    localparam int B_STAT   = 12;
    localparam int B_POL    = 13;
    localparam int B_REMOTE = 14;
    localparam int B_TRIG   = 15;
    localparam int B_MASK   = 16;
    localparam int B_MODE   = 8;
    localparam int B_DEST   = 24;   // inside the high half
    localparam int B_ID     = 24;

    typedef enum logic [MODE_W-1:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_EXT    = 3'd7
    } dmode_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              trig;     // 1 = level
        logic              pol;      // 1 = active low
        logic              dlog;     // 1 = logical
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
    } entry_cfg_t;

    localparam entry_cfg_t CFG_RESET = '{dest: '0, mask: 1'b1, trig: 1'b0,
                                         pol: 1'b0, dlog: 1'b0, mode: '0,
                                         vector: '0};

    function automatic logic [DATA_W-1:0] pack_low(entry_cfg_t c, logic stat,
                                                   logic remote);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VEC_W-1:0]              = c.vector;
        w[B_MODE +: MODE_W]       = c.mode;
        w[B_DLOG]                 = c.dlog;
        w[B_STAT]                 = stat;
        w[B_POL]                  = c.pol;
        w[B_REMOTE]               = remote;
        w[B_TRIG]                 = c.trig;
        w[B_MASK]                 = c.mask;
        return w;
    endfunction

    function automatic entry_cfg_t apply_low(entry_cfg_t c, logic [DATA_W-1:0] w);
        entry_cfg_t r;
        r        = c;
        r.vector = w[VEC_W-1:0];
        r.mode   = w[B_MODE +: MODE_W];
        r.dlog   = w[B_DLOG];
        r.pol    = w[B_POL];
        r.trig   = w[B_TRIG];
        r.mask   = w[B_MASK];
        return r;
    endfunction

endpackage

// File: rtl/intredir_regs.sv
module intredir_regs
    import intredir_pkg::*;
#(
    parameter int N_IN = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [N_IN-1:0]          stat_i,
    input  logic [N_IN-1:0]          remote_i,
    output entry_cfg_t [N_IN-1:0]    cfg_o
);
    localparam int TBL_REGS = 2 * N_IN;
    localparam logic [SEL_W:0] TBL_END = {1'b0, TBL_BASE} + (SEL_W+1)'(TBL_REGS);

    logic [SEL_W-1:0]  sel_q;
    logic [DEST_W-1:0] id_q;
    logic              sel_wr, win_wr, in_tbl, hi_half;
    logic [SEL_W-1:0]  ent_idx;

    assign sel_wr  = bus_wr && (bus_addr == SEL_OFS);
    assign win_wr  = bus_wr && (bus_addr == WIN_OFS);
    assign in_tbl  = (sel_q >= TBL_BASE) && ({1'b0, sel_q} < TBL_END);
    assign ent_idx = (sel_q - TBL_BASE) >> 1;
    assign hi_half = sel_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (sel_wr)
                sel_q <= bus_wdata[SEL_W-1:0];
            if (win_wr && sel_q == ID_IDX)
                id_q <= bus_wdata[B_ID +: DEST_W];
        end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                cfg_o[i] <= CFG_RESET;
            else if (win_wr && in_tbl && ent_idx == SEL_W'(i)) begin
                if (hi_half)
                    cfg_o[i].dest <= bus_wdata[B_DEST +: DEST_W];
                else
                    cfg_o[i] <= apply_low(cfg_o[i], bus_wdata);
            end
        end
    end

    logic [DATA_W-1:0] win_data;
    always_comb begin
        win_data = '0;
        if (sel_q == ID_IDX)
            win_data[B_ID +: DEST_W] = id_q;
        else if (in_tbl) begin
            for (int i = 0; i < N_IN; i++) begin
                if (ent_idx == SEL_W'(i)) begin
                    if (hi_half)
                        win_data[B_DEST +: DEST_W] = cfg_o[i].dest;
                    else
                        win_data = pack_low(cfg_o[i], stat_i[i], remote_i[i]);
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == SEL_OFS)
            bus_rdata[SEL_W-1:0] = sel_q;
        else if (bus_addr == WIN_OFS)
            bus_rdata = win_data;
    end
endmodule

// File: rtl/intredir_src.sv
module intredir_src
    import intredir_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             pol_i,
    input  logic             trig_i,
    input  logic             mask_i,
    input  logic [VEC_W-1:0] vector_i,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             acc_i,
    output logic             req_o,
    output logic             stat_o,
    output logic             remote_o
);
    logic act, act_q, pend_q, rise, eoi_hit;

    assign act     = line_i ^ pol_i;
    assign rise    = act && !act_q;
    assign eoi_hit = eoi_valid && (eoi_vector == vector_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            pend_q   <= 1'b0;
            remote_o <= 1'b0;
        end else begin
            act_q <= act;
            if (trig_i || acc_i)
                pend_q <= 1'b0;
            else if (rise && !mask_i)
                pend_q <= 1'b1;
            if (acc_i && trig_i)
                remote_o <= 1'b1;
            else if (!trig_i || eoi_hit)
                remote_o <= 1'b0;
        end
    end

    assign req_o  = !mask_i && (trig_i ? (act_q && !remote_o) : pend_q);
    assign stat_o = trig_i ? req_o : pend_q;
endmodule

// File: rtl/intredir_arb.sv
module intredir_arb
    import intredir_pkg::*;
#(
    parameter int N_IN = 24
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_IN-1:0]           req_i,
    input  entry_cfg_t [N_IN-1:0]     cfg_i,
    input  logic                      msg_ready,
    output logic                      msg_valid,
    output logic [VEC_W-1:0]          msg_vector,
    output logic [MODE_W-1:0]         msg_mode,
    output logic                      msg_dest_logical,
    output logic [DEST_W-1:0]         msg_dest,
    output logic [$clog2(N_IN)-1:0]   msg_idx,
    output logic [N_IN-1:0]           acc_o
);
    localparam int IDX_W = $clog2(N_IN);

    logic             found;
    logic [IDX_W-1:0] pick;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (req_i[i] && !found) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid        <= 1'b0;
            msg_idx          <= '0;
            msg_vector       <= '0;
            msg_mode         <= '0;
            msg_dest_logical <= 1'b0;
            msg_dest         <= '0;
        end else if (msg_valid) begin
            if (msg_ready)
                msg_valid <= 1'b0;
        end else if (found) begin
            msg_valid        <= 1'b1;
            msg_idx          <= pick;
            msg_vector       <= cfg_i[pick].vector;
            msg_mode         <= cfg_i[pick].mode;
            msg_dest_logical <= cfg_i[pick].dlog;
            msg_dest         <= cfg_i[pick].dest;
        end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_acc
        assign acc_o[i] = msg_valid && msg_ready && (msg_idx == IDX_W'(i));
    end
endmodule

// File: rtl/intredir_top.sv
module intredir_top
    import intredir_pkg::*;
#(
    parameter int N_IN = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [N_IN-1:0]      irq_in,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [VEC_W-1:0]     msg_vector,
    output logic [MODE_W-1:0]    msg_mode,
    output logic                 msg_dest_logical,
    output logic [DEST_W-1:0]    msg_dest,
    input  logic                 eoi_valid,
    input  logic [VEC_W-1:0]     eoi_vector
);
    localparam int IDX_W = $clog2(N_IN);

    entry_cfg_t [N_IN-1:0] cfg;
    logic [N_IN-1:0]       req, stat, remote, acc, mask_v, trig_v;
    logic [IDX_W-1:0]      msg_idx;

    intredir_regs #(.N_IN(N_IN)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stat_i(stat), .remote_i(remote), .cfg_o(cfg)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_src
        assign mask_v[i] = cfg[i].mask;
        assign trig_v[i] = cfg[i].trig;
        intredir_src u_src (
            .clk(clk), .rst(rst), .line_i(irq_in[i]),
            .pol_i(cfg[i].pol), .trig_i(cfg[i].trig), .mask_i(cfg[i].mask),
            .vector_i(cfg[i].vector), .eoi_valid(eoi_valid),
            .eoi_vector(eoi_vector), .acc_i(acc[i]),
            .req_o(req[i]), .stat_o(stat[i]), .remote_o(remote[i])
        );
    end

    intredir_arb #(.N_IN(N_IN)) u_arb (
        .clk(clk), .rst(rst), .req_i(req), .cfg_i(cfg),
        .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_vector(msg_vector), .msg_mode(msg_mode),
        .msg_dest_logical(msg_dest_logical), .msg_dest(msg_dest),
        .msg_idx(msg_idx), .acc_o(acc)
    );
endmodule

// File: rtl/intredir_chk.sv
module intredir_chk #(
    parameter int N_IN = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    msg_valid,
    input logic                    msg_ready,
    input logic [7:0]              msg_vector,
    input logic [7:0]              msg_dest,
    input logic [$clog2(N_IN)-1:0] msg_idx,
    input logic [N_IN-1:0]         req,
    input logic [N_IN-1:0]         acc,
    input logic [N_IN-1:0]         remote,
    input logic [N_IN-1:0]         mask_v,
    input logic [N_IN-1:0]         trig_v
);
    logic [N_IN-1:0] idx_bit, below_idx;
    assign idx_bit   = N_IN'(1) << msg_idx;
    assign below_idx = idx_bit - N_IN'(1);

    // R5
    reset_idle_chk: assert property (@(posedge clk) rst |=> !msg_valid);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
                                       && $stable(msg_dest) && $stable(msg_idx)));

    // R6
    masked_silent_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> (($past(mask_v) & idx_bit) == '0));

    // R10
    lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> (($past(req) & below_idx) == '0));

    // R10
    one_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(acc));

    // R11
    level_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (|(acc & trig_v)) |=> (|(remote & $past(acc))));
endmodule

bind intredir_top intredir_chk #(.N_IN(N_IN)) u_chk (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_idx(msg_idx),
    .req(req), .acc(acc), .remote(remote), .mask_v(mask_v), .trig_v(trig_v)
);

// File: tb/sim_intredir_top.sv
module sim_intredir_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [N-1:0] irq_in;
    logic        msg_valid, msg_ready, msg_dest_logical, eoi_valid;
    logic [7:0]  msg_vector, msg_dest, eoi_vector;
    logic [2:0]  msg_mode;

    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intredir_top #(.N_IN(N)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_dest_logical(msg_dest_logical),
        .msg_dest(msg_dest), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] low(input logic [7:0] vec, input logic [2:0] md,
                                        input logic dl, input logic pl,
                                        input logic tg, input logic mk);
        return {15'b0, mk, tg, 1'b0, pl, 1'b0, dl, md, vec};
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(5'h00, {24'b0, idx});
        bus_write(5'h10, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
        bus_write(5'h00, {24'b0, idx});
        bus_addr = 5'h10;
        #1 d = bus_rdata;
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        step(1);
        msg_ready = 1'b0;
    endtask

    task automatic send_eoi(input logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v;
        step(1);
        eoi_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R5 msg_valid after reset", 32'(msg_valid), 0);
        reg_read(8'h00, d);           check("R5 R2 id reset", d, 0);
        reg_read(8'h10, d);           check("R5 entry0 low", d, 32'h0001_0000);
        reg_read(8'h10 + 8'd46, d);   check("R5 entry23 low", d, 32'h0001_0000);
        reg_read(8'h11 + 8'd46, d);   check("R5 entry23 high", d, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_read(8'h00, d);           check("R2 id readback", d, 32'hFF00_0000);
        bus_addr = 5'h00; #1;         check("R1 select readback", bus_rdata, 32'h0000_0000);
        bus_write(5'h00, 32'h0000_0037);
        bus_addr = 5'h00; #1;         check("R1 select readback 0x37", bus_rdata, 32'h37);
        bus_addr = 5'h08; #1;         check("R1 other offset reads 0", bus_rdata, 0);
        reg_write(8'h3F, 32'hFFFF_FFFF);
        reg_read(8'h3F, d);           check("R3 entry23 high dest", d, 32'hFF00_0000);
        reg_write(8'h40, 32'hFFFF_FFFF);
        reg_read(8'h40, d);           check("R3 unmapped 0x40", d, 0);
        reg_read(8'h05, d);           check("R3 unmapped 0x05", d, 0);
        reg_write(8'h38, 32'h0001_5000);
        reg_read(8'h38, d);           check("R4 status/remote read-only", d, 32'h0001_0000);
    endtask

    task automatic t_masked();
        irq_in[3] = 1'b1;
        step(5);
        check("R6 masked line silent", 32'(msg_valid), 0);
        reg_write(8'h16, low(8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        step(4);
        check("R6 edge while masked forgotten", 32'(msg_valid), 0);
        irq_in[3] = 1'b0;
        step(2);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        reg_write(8'h1A, low(8'h41, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        reg_write(8'h1B, 32'h0700_0000);
        irq_in[5] = 1'b1;
        step(1);
        check("R7 valid not yet after one edge", 32'(msg_valid), 0);
        step(1);
        check("R7 valid after two edges", 32'(msg_valid), 1);
        check("R9 vector", 32'(msg_vector), 32'h41);
        check("R9 dest", 32'(msg_dest), 32'h07);
        check("R9 mode fixed", 32'(msg_mode), 0);
        reg_read(8'h1A, d);
        check("R7 status pending", d, 32'h0000_1041);
        check("R9 held while not ready", {msg_valid, msg_vector}, {1'b1, 8'h41});
        accept();
        check("R10 valid drops after handshake", 32'(msg_valid), 0);
        reg_read(8'h1A, d);
        check("R10 status cleared", d, 32'h0000_0041);
        step(3);
        check("R7 one message per transition", 32'(msg_valid), 0);
        irq_in[5] = 1'b0;
        step(2);
    endtask

    task automatic t_priority();
        reg_write(8'h14, low(8'h22, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0));
        reg_write(8'h15, 32'h0300_0000);
        reg_write(8'h22, low(8'h29, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0));
        irq_in[9] = 1'b1; irq_in[2] = 1'b1;
        step(2);
        check("R10 lowest first vector", {msg_valid, msg_vector}, {1'b1, 8'h22});
        check("R9 mode ext + logical", {msg_mode, msg_dest_logical}, {3'd7, 1'b1});
        check("R9 dest 0x03", 32'(msg_dest), 32'h03);
        accept();
        check("R10 bubble after accept", 32'(msg_valid), 0);
        step(1);
        check("R10 second winner", {msg_valid, msg_vector}, {1'b1, 8'h29});
        check("R9 mode NMI", 32'(msg_mode), 32'd4);
        accept();
        step(2);
        check("R10 queue drained", 32'(msg_valid), 0);
        irq_in[9] = 1'b0; irq_in[2] = 1'b0;
        step(2);
    endtask

    task automatic t_polarity();
        irq_in[11] = 1'b1;
        step(1);
        reg_write(8'h26, low(8'h3B, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0));
        step(3);
        check("R8 high level idle when active low", 32'(msg_valid), 0);
        irq_in[11] = 1'b0;
        step(2);
        check("R8 falling edge triggers", {msg_valid, msg_vector}, {1'b1, 8'h3B});
        accept();
        irq_in[11] = 1'b1;
        step(2);
    endtask

    task automatic t_level();
        logic [31:0] d;
        reg_write(8'h2C, low(8'h5E, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0));
        irq_in[14] = 1'b1;
        step(2);
        check("R11 level message", {msg_valid, msg_vector, 5'b0, msg_mode},
              {1'b1, 8'h5E, 5'b0, 3'd1});
        accept();
        step(4);
        check("R11 locked while remote-busy", 32'(msg_valid), 0);
        reg_read(8'h2C, d);
        check("R11 remote-busy bit", d, 32'h0000_C15E);
        send_eoi(8'h11);
        step(2);
        check("R11 other vector no effect", 32'(msg_valid), 0);
        send_eoi(8'h5E);
        check("R11 not yet re-sent", 32'(msg_valid), 0);
        step(1);
        check("R11 re-sent after matching EOI", {msg_valid, msg_vector}, {1'b1, 8'h5E});
        irq_in[14] = 1'b0;
        accept();
        send_eoi(8'h5E);
        step(3);
        check("R11 inactive line stays quiet", 32'(msg_valid), 0);
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; irq_in = '0;
        msg_ready = 1'b0; eoi_valid = 1'b0; eoi_vector = '0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_regmap();
        t_masked();
        t_edge();
        t_priority();
        t_polarity();
        t_level();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule